// File: doc/BRIEF.md
# Inclusive Snoop Filter Slice

This block is one slice of a distributed coherence directory. For every line held in any private per-core cache whose address maps to this slice, it records a tag, a per-core presence vector and an ownership flag. It stores no line data. The slice sits beside a slice of the shared last-level cache. A private-cache miss is checked against both at the same time. The caller passes in the shared-cache hit result, and the slice reports whether the line must be fetched from memory or from another coherence domain.

Requests arrive on a valid/ready port and are served one at a time. The port accepts a request in a cycle where `req_valid` and `req_ready` are both high. `req_ready` drops the cycle after acceptance and rises again only after the response pulse. The caller must hold the request fields stable while `req_valid` is high and `req_ready` is low. Responses are a single-cycle `rsp_valid` pulse with no back-pressure.

An allocation into a full set evicts an entry chosen by a recently-used-bit policy. The slice sends one back-invalidation to every holder of the evicted entry and waits for an acknowledgement from each one. If any holder reports that it still had the line, the slice presents the victim address on a valid/ready victim port, which must be written into the shared cache. `vic_valid` and `vic_addr` stay fixed until `vic_ready` is high. While an eviction is in progress the request port is not ready. This also holds off any further request to the victim address.

Top module: `snoop_filter_slice`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, and `rsp_valid`, `inv_valid` and `vic_valid` are 0.
- R2: A request is accepted when `req_valid` and `req_ready` are high at a clock edge. `req_ready` is 0 from the following cycle until the response has been given. When no eviction is needed, exactly one `rsp_valid` pulse appears in the cycle after the edge that follows acceptance.
- R3: A lookup (`req_op`=0, code 3 behaves the same) reports `rsp_hit` and, on a hit, the presence vector in `rsp_sharers` (bit i = core i) and `rsp_excl`. A lookup changes no entry.
- R4: `rsp_fetch_remote` equals 1 exactly when the slice misses and `req_llc_hit` was 0 for that request.
- R5: A shared allocation (`req_op`=1, `req_excl`=0) adds the requesting core to the presence vector and clears the ownership flag. Its response reports the hit status and the presence vector as they were before the request.
- R6: An exclusive allocation (`req_op`=1, `req_excl`=1) leaves only the requesting core present and sets the ownership flag.
- R7: An eviction notice (`req_op`=2) clears the requesting core's presence bit. The entry becomes invalid when no bits remain. A notice for an untracked line changes nothing.
- R8: An allocation that misses in a set with an invalid way fills the lowest-numbered invalid way and issues no invalidation.
- R9: Each way has a recently-used bit. An allocation that hits or fills a way sets that way's bit. If that leaves every bit in the set at 1, all bits except that way's are cleared. An allocation that misses in a full set evicts the lowest-numbered way whose bit is 0. It pulses `inv_valid` once, with the victim line address on `inv_addr` and its presence vector on `inv_cores`.
- R10: During an eviction, no response is given and `req_ready` stays 0 until an acknowledgement has arrived from every core in `inv_cores`.
- R11: If any acknowledgement had `ack_kept`=1, `vic_valid` rises with `vic_addr` equal to the evicted address. Both hold until `vic_ready` is sampled high. With no kept acknowledgement, `vic_valid` stays 0.
- R12: The eviction completes with a miss response and installs the new line with only the requesting core present. A later lookup of the evicted address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Slice can accept a request |
| req_op | input | 2 | 0 lookup, 1 allocate, 2 private eviction notice |
| req_addr | input | ADDR_W | Line address; low log2(SETS) bits select the set |
| req_core | input | log2(CORES) | Requesting core |
| req_excl | input | 1 | Allocation is for exclusive/modified ownership |
| req_llc_hit | input | 1 | Shared-cache slice hit for this address |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Line was tracked |
| rsp_excl | output | 1 | Tracked line was held exclusively |
| rsp_sharers | output | CORES | Presence vector before the request |
| rsp_fetch_remote | output | 1 | Line must come from memory or another domain |
| inv_valid | output | 1 | Back-invalidation pulse |
| inv_addr | output | ADDR_W | Address being invalidated |
| inv_cores | output | CORES | Cores that must invalidate |
| ack_valid | input | 1 | Invalidation acknowledgement |
| ack_core | input | log2(CORES) | Acknowledging core |
| ack_kept | input | 1 | Core still held a valid copy |
| vic_valid | output | 1 | Victim write to shared cache requested |
| vic_ready | input | 1 | Shared cache takes the victim |
| vic_addr | output | ADDR_W | Victim line address |

## Verification
A corrupted presence vector shows up at the ports in two ways: on the next lookup of that line, as a wrong `rsp_sharers` value, and on an eviction, as a wrong `inv_cores`. A lost valid bit turns a tracked line into a miss and raises `rsp_fetch_remote` in that same response. Recently-used bits that are out of step are not visible until the set is full. The error then appears when `inv_addr` names the wrong line during the eviction. An acknowledgement counter that is off by one leaves the port stalled or releases it early. The bench checks this between acknowledgements.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_ALLOC  = 2'd1,
    OP_EVICT  = 2'd2,
    OP_RSVD   = 2'd3
  } sf_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_WAIT,
    ST_VIC,
    ST_FILL
  } sf_state_e;
endpackage

// File: rtl/sf_way_match.sv
module sf_way_match #(
  parameter int WAYS  = 12,
  parameter int TAG_W = 14,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            row_vld,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       has_free,
  output logic [WAY_W-1:0]           free_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = row_vld[w] && (row_tag[w] == tag);
  end

  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    has_free = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w] && !hit) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!row_vld[w] && !has_free) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/sf_plru.sv
module sf_plru #(
  parameter int SETS = 64,
  parameter int WAYS = 12,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim_way,
  input  logic             touch,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way
);
  logic [WAYS-1:0] used [SETS];
  logic [WAYS-1:0] onehot, merged;

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!used[rd_set][w] && !found) begin
        found      = 1'b1;
        victim_way = WAY_W'(w);
      end
    end
  end

  assign onehot = WAYS'(1) << touch_way;
  assign merged = used[touch_set] | onehot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) used[s] <= '0;
    end else if (touch) begin
      used[touch_set] <= (&merged) ? onehot : merged;
    end
  end
endmodule

// File: rtl/snoop_filter_slice.sv
module snoop_filter_slice #(
  parameter int ADDR_W = 20,
  parameter int SETS   = 64,
  parameter int WAYS   = 12,
  parameter int CORES  = 8,
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - SET_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CORE_W = $clog2(CORES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CORE_W-1:0] req_core,
  input  logic              req_excl,
  input  logic              req_llc_hit,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_excl,
  output logic [CORES-1:0]  rsp_sharers,
  output logic              rsp_fetch_remote,
  output logic              inv_valid,
  output logic [ADDR_W-1:0] inv_addr,
  output logic [CORES-1:0]  inv_cores,
  input  logic              ack_valid,
  input  logic [CORE_W-1:0] ack_core,
  input  logic              ack_kept,
  output logic              vic_valid,
  input  logic              vic_ready,
  output logic [ADDR_W-1:0] vic_addr
);
  import sf_pkg::*;

  // directory storage: tag and presence only
  logic             ent_vld [SETS][WAYS];
  logic [TAG_W-1:0] ent_tag [SETS][WAYS];
  logic [CORES-1:0] ent_own [SETS][WAYS];
  logic             ent_ex  [SETS][WAYS];

  sf_state_e         state;
  sf_op_e            op_q;
  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;
  logic [CORE_W-1:0] core_q;
  logic              excl_q, llc_q;
  logic [WAY_W-1:0]  vway_q;
  logic [CORES-1:0]  pend_q;
  logic              kept_q;

  logic [WAYS-1:0]             row_vld;
  logic [WAYS-1:0][TAG_W-1:0]  row_tag;
  logic [CORES-1:0]            row_own [WAYS];
  logic [WAYS-1:0]             row_ex;

  logic             hit, has_free;
  logic [WAY_W-1:0] hit_way, free_way, plru_way;
  logic [CORES-1:0] hit_own, core_bit, ack_bit, pend_nx;
  logic             hit_ex, kept_nx;

  logic             wr_en, wr_vld, wr_ex, touch, need_evict;
  logic [WAY_W-1:0] wr_way, touch_way;
  logic [CORES-1:0] wr_own;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      row_vld[w] = ent_vld[set_q][w];
      row_tag[w] = ent_tag[set_q][w];
      row_own[w] = ent_own[set_q][w];
      row_ex[w]  = ent_ex[set_q][w];
    end
  end

  sf_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .row_vld(row_vld), .row_tag(row_tag), .tag(tag_q),
    .hit(hit), .hit_way(hit_way), .has_free(has_free), .free_way(free_way)
  );

  sf_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst_n(rst_n), .rd_set(set_q), .victim_way(plru_way),
    .touch(touch), .touch_set(set_q), .touch_way(touch_way)
  );

  assign hit_own  = row_own[hit_way];
  assign hit_ex   = row_ex[hit_way];
  assign core_bit = CORES'(1) << core_q;
  assign ack_bit  = ack_valid ? (CORES'(1) << ack_core) : '0;
  assign pend_nx  = pend_q & ~ack_bit;
  assign kept_nx  = kept_q | (ack_valid && ack_kept && pend_q[ack_core]);

  // entry update decision
  always_comb begin
    wr_en      = 1'b0;
    wr_way     = hit_way;
    wr_vld     = 1'b1;
    wr_own     = core_bit;
    wr_ex      = excl_q;
    touch      = 1'b0;
    touch_way  = hit_way;
    need_evict = 1'b0;
    if (state == ST_EXEC) begin
      case (op_q)
        OP_ALLOC: begin
          if (hit) begin
            wr_en  = 1'b1;
            wr_own = excl_q ? core_bit : (hit_own | core_bit);
            touch  = 1'b1;
          end else if (has_free) begin
            wr_en     = 1'b1;
            wr_way    = free_way;
            touch     = 1'b1;
            touch_way = free_way;
          end else begin
            need_evict = 1'b1;
          end
        end
        OP_EVICT: begin
          if (hit && ((hit_own & core_bit) != '0)) begin
            wr_en  = 1'b1;
            wr_own = hit_own & ~core_bit;
            wr_vld = ((hit_own & ~core_bit) != '0);
            wr_ex  = hit_ex;
          end
        end
        default: ;
      endcase
    end else if (state == ST_FILL) begin
      wr_en     = 1'b1;
      wr_way    = vway_q;
      touch     = 1'b1;
      touch_way = vway_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          ent_vld[s][w] <= 1'b0;
          ent_tag[s][w] <= '0;
          ent_own[s][w] <= '0;
          ent_ex[s][w]  <= 1'b0;
        end
      end
    end else if (wr_en) begin
      ent_vld[set_q][wr_way] <= wr_vld;
      ent_tag[set_q][wr_way] <= tag_q;
      ent_own[set_q][wr_way] <= wr_own;
      ent_ex[set_q][wr_way]  <= wr_ex;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state            <= ST_IDLE;
      op_q             <= OP_LOOKUP;
      set_q            <= '0;
      tag_q            <= '0;
      core_q           <= '0;
      excl_q           <= 1'b0;
      llc_q            <= 1'b0;
      vway_q           <= '0;
      pend_q           <= '0;
      kept_q           <= 1'b0;
      rsp_valid        <= 1'b0;
      rsp_hit          <= 1'b0;
      rsp_excl         <= 1'b0;
      rsp_sharers      <= '0;
      rsp_fetch_remote <= 1'b0;
      inv_valid        <= 1'b0;
      inv_addr         <= '0;
      inv_cores        <= '0;
    end else begin
      rsp_valid <= 1'b0;
      inv_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          op_q   <= sf_op_e'(req_op);
          set_q  <= req_addr[SET_W-1:0];
          tag_q  <= req_addr[ADDR_W-1:SET_W];
          core_q <= req_core;
          excl_q <= req_excl;
          llc_q  <= req_llc_hit;
          state  <= ST_EXEC;
        end
        ST_EXEC: if (need_evict) begin
          vway_q    <= plru_way;
          inv_addr  <= {row_tag[plru_way], set_q};
          inv_cores <= row_own[plru_way];
          pend_q    <= row_own[plru_way];
          kept_q    <= 1'b0;
          inv_valid <= 1'b1;
          state     <= ST_WAIT;
        end else begin
          rsp_valid        <= 1'b1;
          rsp_hit          <= hit;
          rsp_excl         <= hit && hit_ex;
          rsp_sharers      <= hit ? hit_own : '0;
          rsp_fetch_remote <= !hit && !llc_q;
          state            <= ST_IDLE;
        end
        ST_WAIT: begin
          pend_q <= pend_nx;
          kept_q <= kept_nx;
          if (pend_nx == '0) state <= kept_nx ? ST_VIC : ST_FILL;
        end
        ST_VIC: if (vic_ready) state <= ST_FILL;
        ST_FILL: begin
          rsp_valid        <= 1'b1;
          rsp_hit          <= 1'b0;
          rsp_excl         <= 1'b0;
          rsp_sharers      <= '0;
          rsp_fetch_remote <= !llc_q;
          state            <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign vic_valid = (state == ST_VIC);
  assign vic_addr  = inv_addr;
endmodule

// File: rtl/sf_slice_chk.sv
module sf_slice_chk #(
  parameter int ADDR_W = 20,
  parameter int CORES  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              inv_valid,
  input logic [CORES-1:0]  inv_cores,
  input logic              vic_valid,
  input logic              vic_ready,
  input logic [ADDR_W-1:0] vic_addr
);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  inv_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_cores != '0));

  // R10
  inv_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (!req_ready && !rsp_valid));

  // R10
  vic_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> (!req_ready && !rsp_valid));

  // R11
  vic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_addr)));
endmodule

bind snoop_filter_slice sf_slice_chk #(.ADDR_W(ADDR_W), .CORES(CORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .inv_valid(inv_valid), .inv_cores(inv_cores),
  .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_addr(vic_addr)
);

// File: tb/snoop_filter_slice_test.sv
module snoop_filter_slice_test;
  localparam int ADDR_W = 12;
  localparam int SETS   = 8;
  localparam int WAYS   = 4;
  localparam int CORES  = 4;
  localparam int CORE_W = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_excl = 0, req_llc_hit = 0;
  logic [1:0] req_op = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [CORE_W-1:0] req_core = 0;
  logic ack_valid = 0, ack_kept = 0, vic_ready = 0;
  logic [CORE_W-1:0] ack_core = 0;
  logic req_ready, rsp_valid, rsp_hit, rsp_excl, rsp_fetch_remote;
  logic inv_valid, vic_valid;
  logic [CORES-1:0] rsp_sharers, inv_cores;
  logic [ADDR_W-1:0] inv_addr, vic_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  snoop_filter_slice #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .CORES(CORES)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_core(req_core), .req_excl(req_excl),
    .req_llc_hit(req_llc_hit), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_excl(rsp_excl), .rsp_sharers(rsp_sharers), .rsp_fetch_remote(rsp_fetch_remote),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_cores(inv_cores),
    .ack_valid(ack_valid), .ack_core(ack_core), .ack_kept(ack_kept),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_addr(vic_addr)
  );

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
    return ADDR_W'(tag * SETS + set);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int op, input logic [ADDR_W-1:0] a, input int core,
                      input bit ex, input bit llc);
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_addr = a; req_core = CORE_W'(core);
    req_excl = ex; req_llc_hit = llc;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // single-cycle request: response sampled one edge after acceptance
  task automatic op_chk(input string req, input int op, input logic [ADDR_W-1:0] a,
                        input int core, input bit ex, input bit llc,
                        input int e_hit, input int e_sh, input int e_ex, input int e_fr);
    send(op, a, core, ex, llc);
    chk({req, " busy after accept"}, int'(req_ready), 0);
    @(posedge clk); #1;
    chk({req, " rsp_valid"}, int'(rsp_valid), 1);
    chk({req, " hit"}, int'(rsp_hit), e_hit);
    chk({req, " sharers"}, int'(rsp_sharers), e_sh);
    chk({req, " excl"}, int'(rsp_excl), e_ex);
    chk({req, " fetch_remote"}, int'(rsp_fetch_remote), e_fr);
  endtask

  task automatic ack(input int core, input bit kept);
    @(negedge clk);
    ack_valid = 1; ack_core = CORE_W'(core); ack_kept = kept;
    @(posedge clk); #1;
    ack_valid = 0; ack_kept = 0;
  endtask

  task automatic t_reset;
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 inv_valid", int'(inv_valid), 0);
    chk("R1 vic_valid", int'(vic_valid), 0);
    op_chk("R1 empty lookup", 0, mk(3, 1), 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_lookup_remote;
    op_chk("R4 miss llc miss", 0, mk(9, 2), 1, 0, 0, 0, 0, 0, 1);
    op_chk("R4 miss llc hit", 0, mk(9, 2), 1, 0, 1, 0, 0, 0, 0);
    op_chk("R3 reserved op lookup", 3, mk(9, 2), 1, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_shared_alloc;
    op_chk("R8 first alloc", 1, mk(1, 2), 0, 0, 0, 0, 0, 0, 1);
    op_chk("R3 lookup after alloc", 0, mk(1, 2), 3, 0, 0, 1, 4'b0001, 0, 0);
    op_chk("R5 second sharer", 1, mk(1, 2), 2, 0, 1, 1, 4'b0001, 0, 0);
    op_chk("R5 lookup two sharers", 0, mk(1, 2), 0, 0, 0, 1, 4'b0101, 0, 0);
    op_chk("R3 lookup unchanged", 0, mk(1, 2), 0, 0, 0, 1, 4'b0101, 0, 0);
  endtask

  task automatic t_excl_and_evict;
    op_chk("R6 excl alloc", 1, mk(1, 2), 1, 1, 0, 1, 4'b0101, 0, 0);
    op_chk("R6 lookup excl", 0, mk(1, 2), 0, 0, 0, 1, 4'b0010, 1, 0);
    op_chk("R7 evict non-holder", 2, mk(1, 2), 3, 0, 0, 1, 4'b0010, 1, 0);
    op_chk("R7 non-holder no effect", 0, mk(1, 2), 0, 0, 0, 1, 4'b0010, 1, 0);
    op_chk("R7 evict last holder", 2, mk(1, 2), 1, 0, 0, 1, 4'b0010, 1, 0);
    op_chk("R7 freed entry", 0, mk(1, 2), 1, 0, 0, 0, 0, 0, 1);
    op_chk("R5 two sharers again", 1, mk(2, 2), 0, 0, 0, 0, 0, 0, 1);
    op_chk("R5 add core3", 1, mk(2, 2), 3, 0, 0, 1, 4'b0001, 0, 0);
    op_chk("R7 evict one of two", 2, mk(2, 2), 0, 0, 0, 1, 4'b1001, 0, 0);
    op_chk("R7 remaining sharer", 0, mk(2, 2), 0, 0, 0, 1, 4'b1000, 0, 0);
    op_chk("R7 untracked evict", 2, mk(7, 2), 2, 0, 0, 0, 0, 0, 1);
    op_chk("R7 untracked stays miss", 0, mk(7, 2), 2, 0, 0, 0, 0, 0, 1);
  endtask

  // set 5: fill four ways, re-touch way0, next victim is way1 (tag 11)
  task automatic t_conflict_kept;
    op_chk("R8 fill w0", 1, mk(10, 5), 0, 0, 0, 0, 0, 0, 1);
    op_chk("R8 fill w1", 1, mk(11, 5), 0, 0, 0, 0, 0, 0, 1);
    op_chk("R9 touch w1", 1, mk(11, 5), 2, 0, 0, 1, 4'b0001, 0, 0);
    op_chk("R8 fill w2", 1, mk(12, 5), 0, 0, 0, 0, 0, 0, 1);
    op_chk("R8 fill w3", 1, mk(13, 5), 1, 0, 0, 0, 0, 0, 1);
    op_chk("R9 touch w0", 1, mk(10, 5), 0, 0, 0, 1, 4'b0001, 0, 0);
    send(1, mk(14, 5), 3, 0, 0);
    @(posedge clk); #1;
    chk("R9 inv_valid", int'(inv_valid), 1);
    chk("R9 inv_addr", int'(inv_addr), int'(mk(11, 5)));
    chk("R9 inv_cores", int'(inv_cores), 4'b0101);
    chk("R10 not ready", int'(req_ready), 0);
    @(posedge clk); #1;
    chk("R9 inv single pulse", int'(inv_valid), 0);
    ack(0, 0);
    chk("R10 stall after one ack", int'(req_ready), 0);
    chk("R10 no rsp after one ack", int'(rsp_valid), 0);
    chk("R11 no vic yet", int'(vic_valid), 0);
    ack(2, 1);
    chk("R11 vic_valid", int'(vic_valid), 1);
    chk("R11 vic_addr", int'(vic_addr), int'(mk(11, 5)));
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R11 vic held", int'(vic_valid), 1);
    chk("R11 vic addr held", int'(vic_addr), int'(mk(11, 5)));
    chk("R10 stall during vic", int'(req_ready), 0);
    @(negedge clk); vic_ready = 1;
    @(posedge clk); #1; vic_ready = 0;
    chk("R11 vic dropped", int'(vic_valid), 0);
    @(posedge clk); #1;
    chk("R12 rsp after evict", int'(rsp_valid), 1);
    chk("R12 rsp miss", int'(rsp_hit), 0);
    chk("R12 rsp fetch", int'(rsp_fetch_remote), 1);
    op_chk("R12 victim gone", 0, mk(11, 5), 0, 0, 0, 0, 0, 0, 1);
    op_chk("R12 new line", 0, mk(14, 5), 0, 0, 0, 1, 4'b1000, 0, 0);
  endtask

  // used bits now {0,1,3}: victim is way2 (tag 12, core0 only)
  task automatic t_conflict_clean;
    send(1, mk(15, 5), 1, 1, 1);
    @(posedge clk); #1;
    chk("R9 second inv_addr", int'(inv_addr), int'(mk(12, 5)));
    chk("R9 second inv_cores", int'(inv_cores), 4'b0001);
    ack(0, 0);
    chk("R11 no vic when clean", int'(vic_valid), 0);
    chk("R10 no rsp yet", int'(rsp_valid), 0);
    @(posedge clk); #1;
    chk("R11 still no vic", int'(vic_valid), 0);
    chk("R12 clean rsp", int'(rsp_valid), 1);
    chk("R12 clean rsp llc hit", int'(rsp_fetch_remote), 0);
    op_chk("R12 clean victim gone", 0, mk(12, 5), 0, 0, 0, 0, 0, 0, 1);
    op_chk("R12 new excl line", 0, mk(15, 5), 0, 0, 0, 1, 4'b0010, 1, 0);
    op_chk("R12 other lines kept", 0, mk(10, 5), 0, 0, 0, 1, 4'b0001, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_lookup_remote();
    t_shared_alloc();
    t_excl_and_evict();
    t_conflict_kept();
    t_conflict_clean();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule